// File: doc/BRIEF.md
# Microsecond tick fractional prescaler

This block makes a one-microsecond time base from a reference clock that may run at any of several crystal frequencies. Software programs a ratio of M ticks per N reference cycles. A fractional accumulator then spreads the M ticks over every window of N cycles. This keeps the long-term rate exact when the reference frequency is not a whole number of megahertz: a 19.2 MHz reference uses M=5, N=96. Whole-megahertz references use M=1 with N equal to the frequency in MHz, for example 12, 13 or 26.

Each tick advances a free-running microsecond counter. Software reads the counter over a simple register port. A freeze input stops the counter without disturbing the accumulator, so the tick phase is kept while the count is held.

Top module: `usec_prescaler`

## Requirements
- R1: After reset the counter reads 0, the ratio register reads 0x0000000B (M=1, N=12) and `usec_tick` is low.
- R2: The ratio register sits at offset 0x14. Bits 7:0 hold N−1 and bits 15:8 hold M−1. Bits 31:16 are discarded on write and read back as zero.
- R3: A ratio write clears the accumulator in the write cycle itself and makes no step in that cycle. The new ratio applies from the next cycle, so exactly floor(K·M/N) ticks occur in the K cycles that follow.
- R4: With M=1 there is one tick every N cycles.
- R5: With a non-integer ratio such as M=5, N=96, the tick count stays within one tick of K·M/N at every point, and it is exact at every multiple of N cycles.
- R6: When M exceeds N, M is treated as N and a tick occurs every cycle.
- R7: While `freeze` is high at a clock edge the counter holds its value. The accumulator keeps stepping, and the ticks of that window are not applied later.
- R8: The counter is read at offset 0x10 and wraps modulo 2^CNT_W (32 by default).
- R9: Reads from any offset other than 0x10 and 0x14 return 0. Writes to any offset other than 0x14 change nothing.
- R10: `usec_tick` is high for one cycle per accumulator crossing, in the cycle after the edge at which the counter advanced, and it pulses whether or not `freeze` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| freeze | input | 1 | Holds the microsecond counter while high |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational on bus_addr |
| usec_tick | output | 1 | One-cycle pulse per microsecond tick |

## Verification
Directed ratios of 1/12, 1/13 and 1/26 separate correct integer stepping from an off-by-one in the N−1 field decode. The 5/96 ratio is sampled both mid-window and at a multiple of N, which exposes a wrong fractional remainder. An M>N setting and an M=N setting, the latter driven into a narrow counter until it wraps, cover the clamp and the wrap. Random ratios with random frozen stretches are compared against floor(K·M/N) arithmetic. This tells a freeze that wrongly stalls the accumulator apart from one that only holds the count, and it checks that a ratio write really restarts the phase.

// File: rtl/usec_pkg.sv
package usec_pkg;

   typedef enum logic [1:0] {
      SEL_NONE  = 2'd0,
      SEL_COUNT = 2'd1,
      SEL_RATIO = 2'd2
   } reg_sel_e;

endpackage

// File: rtl/usec_ratio_reg.sv
module usec_ratio_reg #(
   parameter int unsigned FLD_W  = 8,
   parameter int unsigned RST_M1 = 0,
   parameter int unsigned RST_N1 = 11
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [2*FLD_W-1:0] wr_val,
   output logic [FLD_W-1:0]   m_minus1,
   output logic [FLD_W-1:0]   n_minus1
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_minus1 <= FLD_W'(RST_M1);
         n_minus1 <= FLD_W'(RST_N1);
      end else if (wr_en) begin
         m_minus1 <= wr_val[2*FLD_W-1:FLD_W];
         n_minus1 <= wr_val[FLD_W-1:0];
      end
   end

endmodule

// File: rtl/usec_frac_acc.sv
module usec_frac_acc #(
   parameter int unsigned FLD_W   = 8,
   parameter bit          CLAMP_M = 1'b1,
   localparam int unsigned ACC_W  = FLD_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [FLD_W-1:0] m_minus1,
   input  logic [FLD_W-1:0] n_minus1,
   output logic             step_o,
   output logic             tick_o,
   output logic [ACC_W-1:0] acc_o
);

   logic [ACC_W-1:0] m_val, n_val, m_eff, sum, nxt, acc_q;
   logic             hit;

   assign m_val = ACC_W'(m_minus1) + ACC_W'(1);
   assign n_val = ACC_W'(n_minus1) + ACC_W'(1);

   generate
      if (CLAMP_M) begin : g_clamp
         assign m_eff = (m_val > n_val) ? n_val : m_val;
      end else begin : g_raw
         assign m_eff = m_val;
      end
   endgenerate

   assign sum    = acc_q + m_eff;
   assign hit    = (sum >= n_val);
   assign nxt    = hit ? (sum - n_val) : sum;
   assign step_o = hit & ~clr;
   assign acc_o  = acc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         tick_o <= 1'b0;
      end else if (clr) begin
         acc_q  <= '0;
         tick_o <= 1'b0;
      end else begin
         acc_q  <= nxt;
         tick_o <= hit;
      end
   end

endmodule

// File: rtl/usec_counter.sv
module usec_counter #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             hold,
   output logic [CNT_W-1:0] count_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count_o <= '0;
      else if (inc && !hold)
         count_o <= count_o + CNT_W'(1);
   end

endmodule

// File: rtl/usec_prescaler.sv
module usec_prescaler
   import usec_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned CNT_W     = 32,
   parameter int unsigned FLD_W     = 8,
   parameter int unsigned COUNT_OFS = 'h10,
   parameter int unsigned RATIO_OFS = 'h14,
   parameter int unsigned RST_M1    = 0,
   parameter int unsigned RST_N1    = 11,
   parameter bit          CLAMP_M   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              freeze,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              usec_tick
);

   localparam int unsigned RATIO_W = 2 * FLD_W;
   localparam int unsigned ACC_W   = FLD_W + 1;

   generate
      if (CNT_W > DATA_W || CNT_W < 2) begin : g_bad_cnt
         $error("usec_prescaler: CNT_W must lie in 2..DATA_W");
      end
      if (RATIO_W > DATA_W) begin : g_bad_fld
         $error("usec_prescaler: two ratio fields must fit in DATA_W");
      end
      if (COUNT_OFS == RATIO_OFS) begin : g_bad_ofs
         $error("usec_prescaler: register offsets must differ");
      end
   endgenerate

   reg_sel_e          sel;
   logic              cfg_wr, step;
   logic [FLD_W-1:0]  cfg_m1, cfg_n1;
   logic [ACC_W-1:0]  acc_q;
   logic [CNT_W-1:0]  count_q;
   logic [DATA_W-1:0] count_ext, ratio_ext;

   always_comb begin
      if (bus_addr == ADDR_W'(COUNT_OFS))      sel = SEL_COUNT;
      else if (bus_addr == ADDR_W'(RATIO_OFS)) sel = SEL_RATIO;
      else                                     sel = SEL_NONE;
   end

   assign cfg_wr = bus_wr && (sel == SEL_RATIO);

   usec_ratio_reg #(.FLD_W(FLD_W), .RST_M1(RST_M1), .RST_N1(RST_N1)) u_ratio (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_wr),
      .wr_val   (bus_wdata[RATIO_W-1:0]),
      .m_minus1 (cfg_m1),
      .n_minus1 (cfg_n1)
   );

   usec_frac_acc #(.FLD_W(FLD_W), .CLAMP_M(CLAMP_M)) u_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (cfg_wr),
      .m_minus1 (cfg_m1),
      .n_minus1 (cfg_n1),
      .step_o   (step),
      .tick_o   (usec_tick),
      .acc_o    (acc_q)
   );

   usec_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc     (step),
      .hold    (freeze),
      .count_o (count_q)
   );

   generate
      if (CNT_W == DATA_W) begin : g_cnt_full
         assign count_ext = count_q;
      end else begin : g_cnt_pad
         assign count_ext = {{(DATA_W-CNT_W){1'b0}}, count_q};
      end
      if (RATIO_W == DATA_W) begin : g_rat_full
         assign ratio_ext = {cfg_m1, cfg_n1};
      end else begin : g_rat_pad
         logic unused_wdata_hi;
         assign unused_wdata_hi = ^bus_wdata[DATA_W-1:RATIO_W];
         assign ratio_ext = {{(DATA_W-RATIO_W){1'b0}}, cfg_m1, cfg_n1};
      end
   endgenerate

   always_comb begin
      unique case (sel)
         SEL_COUNT: bus_rdata = count_ext;
         SEL_RATIO: bus_rdata = ratio_ext;
         default:   bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/usec_prescaler_chk.sv
module usec_prescaler_chk #(
   parameter int unsigned CNT_W = 32,
   parameter int unsigned FLD_W = 8,
   parameter bit          CLAMP_M = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             freeze,
   input logic             cfg_wr,
   input logic [FLD_W-1:0] cfg_m1,
   input logic [FLD_W-1:0] cfg_n1,
   input logic [FLD_W:0]   acc_q,
   input logic             usec_tick,
   input logic [CNT_W-1:0] count_q
);

   // R10
   tick_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (usec_tick && !$past(freeze)) |-> (count_q == CNT_W'($past(count_q) + CNT_W'(1))));

   // R7
   freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(freeze) |-> $stable(count_q));

   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !usec_tick |-> $stable(count_q));

   // R3
   wr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> (!usec_tick && acc_q == '0));

   // R5
   acc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_q < ({1'b0, cfg_n1} + 1'b1));

   // R6
   clamp_every_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (CLAMP_M && cfg_m1 >= cfg_n1 && !cfg_wr) |=> usec_tick);

endmodule

bind usec_prescaler usec_prescaler_chk #(.CNT_W(CNT_W), .FLD_W(FLD_W), .CLAMP_M(CLAMP_M)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .freeze    (freeze),
   .cfg_wr    (cfg_wr),
   .cfg_m1    (cfg_m1),
   .cfg_n1    (cfg_n1),
   .acc_q     (acc_q),
   .usec_tick (usec_tick),
   .count_q   (count_q)
);

// File: tb/usec_prescaler_test.sv
module usec_prescaler_test;

   localparam logic [7:0] OFS_CNT = 8'h10;
   localparam logic [7:0] OFS_RAT = 8'h14;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        freeze = 1'b0;
   logic [7:0]  bus_addr = OFS_CNT;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata, nar_rdata;
   logic        usec_tick, nar_tick;

   int compared = 0;
   int mismatched = 0;
   int ticks_seen = 0;

   always #5 clk = ~clk;

   usec_prescaler uut (
      .clk(clk), .rst_n(rst_n), .freeze(freeze), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .usec_tick(usec_tick)
   );

   usec_prescaler #(.CNT_W(8)) uut_narrow (
      .clk(clk), .rst_n(rst_n), .freeze(freeze), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(nar_rdata),
      .usec_tick(nar_tick)
   );

   function automatic longint unsigned expect_ticks(longint unsigned k, int unsigned m1, int unsigned n1);
      longint unsigned m = m1 + 1;
      longint unsigned n = n1 + 1;
      if (m > n) m = n;
      return (k * m) / n;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   // all tasks start and end just after a falling edge
   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = OFS_CNT;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] v, output logic [31:0] vn);
      bus_addr = a;
      #1;
      v = bus_rdata; vn = nar_rdata;
   endtask

   task automatic run(input int k, input logic frz);
      for (int i = 0; i < k; i++) begin
         freeze = frz;
         @(negedge clk);
         if (usec_tick) ticks_seen++;
      end
      freeze = 1'b0;
   endtask

   task automatic ratio_case(input string req, input int unsigned m1, input int unsigned n1,
                             input int kf, input int kr);
      logic [31:0] base, basen, v, vn;
      longint unsigned adv;
      wr(OFS_RAT, {16'h0, m1[7:0], n1[7:0]});
      rd(OFS_CNT, base, basen);
      ticks_seen = 0;
      run(kf, 1'b1);
      run(kr, 1'b0);
      adv = expect_ticks(kf + kr, m1, n1) - expect_ticks(kf, m1, n1);
      rd(OFS_CNT, v, vn);
      chk(req, v, base + 32'(adv));
      chk({req, "/R8 narrow"}, vn, (basen + 32'(adv)) & 32'hFF);
      chk({req, "/R10 pulses"}, 32'(ticks_seen), 32'(expect_ticks(kf + kr, m1, n1)));
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      logic [31:0] v, vn, base, basen;
      void'($urandom(32'h1D5E_0CA7));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(OFS_CNT, v, vn);
      chk("R1 count", v, 32'h0);
      rd(OFS_RAT, v, vn);
      chk("R1 ratio", v, 32'h0000_000B);
      chk("R1 tick", {31'h0, usec_tick}, 32'h0);

      // R4 default 1/12 from reset
      ticks_seen = 0;
      run(120, 1'b0);
      rd(OFS_CNT, v, vn);
      chk("R4 default 1/12", v, 32'd10);
      chk("R10 default pulses", 32'(ticks_seen), 32'd10);

      // R4 integer ratios
      ratio_case("R4 1/13", 0, 12, 0, 130);
      ratio_case("R4 1/26", 0, 25, 0, 77);

      // R5 fractional 5/96: mid-window and exact multiple
      ratio_case("R5 5/96 partial", 4, 95, 0, 95);
      ratio_case("R5 5/96 exact", 4, 95, 0, 960);

      // R6 clamp M>N
      ratio_case("R6 21/10", 20, 9, 0, 50);

      // R7 freeze keeps accumulator phase
      ratio_case("R7 5/96 frozen", 4, 95, 50, 142);

      // R2, R9 field packing and ignored writes
      wr(OFS_RAT, 32'hABCD_0405);
      rd(OFS_RAT, v, vn);
      chk("R2 upper bits dropped", v, 32'h0000_0405);
      rd(OFS_CNT, base, basen);
      wr(OFS_CNT, 32'hFFFF_FFFF);
      wr(8'h18, 32'h0000_0000);
      run(98, 1'b0);
      rd(OFS_CNT, v, vn);
      chk("R9 write to count ignored", v, base + 32'(expect_ticks(100, 4, 5)));
      rd(OFS_RAT, v, vn);
      chk("R9 write to unmapped ignored", v, 32'h0000_0405);
      rd(8'h18, v, vn);
      chk("R9 unmapped read 0x18", v, 32'h0);
      rd(8'h00, v, vn);
      chk("R9 unmapped read 0x00", v, 32'h0);

      // R8 wrap of narrow counter with M=N
      ratio_case("R8 wrap 2/2", 1, 1, 0, 300);

      // R3 random ratios with random frozen stretches
      for (int it = 0; it < 20; it++) begin
         int unsigned m1 = $urandom_range(0, 255);
         int unsigned n1 = $urandom_range(0, 255);
         int kf = $urandom_range(0, 300);
         int kr = $urandom_range(1, 2000);
         ratio_case("R3 random", m1, n1, kf, kr);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule